// File: doc/BRIEF.md
# Latch-Based Interrupt Type Generator

This block is the smallest useful external interrupt front end for a processor that has a single level-sensitive request input and fetches a type byte over its data bus during a two-pulse acknowledge sequence. Up to seven peripheral request lines, each active low, enter the block. A single gate combines them, so the processor's request output goes high while any line is low.

When the processor acknowledges, the first strobe pulse freezes the request lines in a register. The frozen pattern is the low seven bits of the type byte, and bit 7 is always 1. During the second strobe pulse the block drives that byte onto data bits 7:0. At all other times it releases the bus.

The block has no priority resolver. When several lines are active together, their low bits merge into one code. Priority is set by where software places each service routine in the vector table for every code that can occur. On-chip, the bus release is an output-enable, and the data value is held at zero while the enable is low.

Top module: `irq_type_gen`

## Requirements
- R1: `int_req_o` is high in the same cycle whenever at least one bit of `irq_ni` is 0, and low when all bits are 1. It is combinational and has no clock delay.
- R2: After reset is released, `data_oe_o` is 0 and `data_o` is 8'h00, and the sequencer waits for a first acknowledge pulse.
- R3: The first clock edge that sees `inta_ni` low after it was high, with the sequencer idle, captures `irq_ni`. Bit i of the type byte equals `irq_ni[i]` for i in 0..6.
- R4: Bit 7 of the driven type byte is always 1. Examples: only line 0 low gives 8'hFE, and lines 0 and 1 both low give 8'hFC.
- R5: Changes on `irq_ni` after the capture edge do not alter the byte driven during the second pulse.
- R6: During the second acknowledge pulse, `data_oe_o` goes high from the first clock edge that sees `inta_ni` low. It drops in the same cycle that `inta_ni` returns high.
- R7: Outside the second pulse, including the whole first pulse, `data_oe_o` is 0 and `data_o` is 8'h00.
- R8: Once the second pulse ends, the sequencer returns to idle. The next falling strobe is treated as a new first pulse and recaptures the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | 7 | Request lines, active low |
| inta_ni | input | 1 | Acknowledge strobe, active low, two pulses per sequence |
| int_req_o | output | 1 | Request to processor, active high |
| data_o | output | 8 | Type byte on data bits 7:0 |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench sweeps all 128 request patterns through a full acknowledge sequence. It checks the request gate and the merged type byte for each one.

Between the two pulses it drives the complementary pattern on the lines. A design that samples the lines late, or passes them through without a latch, then shows the wrong byte.

It also checks the bus enable at three points: during the first pulse, in the cycle the second pulse begins, and in the cycle the strobe rises. A design that drives too early, or holds the bus after release, is caught at one of these points.

Running back-to-back sequences exposes a sequencer that fails to return to idle, because it would skip the next capture.

// File: rtl/irq_type_pkg.sv
package irq_type_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } ack_phase_e;
endpackage

// File: rtl/int_req_gate.sv
module int_req_gate #(
  parameter int NUM_REQ = 7
) (
  input  logic [NUM_REQ-1:0] irq_ni,
  output logic               int_req_o
);
  // NAND of the active-low lines
  assign int_req_o = ~&irq_ni;
endmodule

// File: rtl/ack_sequencer.sv
module ack_sequencer
  import irq_type_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inta_ni,
  output logic capture_o,
  output logic drive_o
);
  ack_phase_e phase_q, phase_d;
  logic       inta_q;
  logic       fall, rise;

  assign fall = inta_q & ~inta_ni;
  assign rise = ~inta_q & inta_ni;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (fall) phase_d = PH_FIRST;
      PH_FIRST:  if (fall) phase_d = PH_SECOND;
      PH_SECOND: if (rise || inta_ni) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      inta_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      inta_q  <= inta_ni;
    end
  end

  assign capture_o = fall && (phase_q == PH_IDLE);
  // release is combinational on strobe rise
  assign drive_o   = (phase_q == PH_SECOND) && !inta_ni;
endmodule

// File: rtl/type_latch.sv
module type_latch #(
  parameter int NUM_REQ = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic [NUM_REQ-1:0] irq_ni,
  output logic [NUM_REQ:0]   type_o
);
  logic [NUM_REQ-1:0] held_q;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        held_q[i] <= 1'b1;
      else if (capture_i) held_q[i] <= irq_ni[i];
    end
  end

  assign type_o = {1'b1, held_q};
endmodule

// File: rtl/irq_type_gen.sv
module irq_type_gen #(
  parameter int NUM_REQ = 7,
  localparam int TYPE_W = NUM_REQ + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] irq_ni,
  input  logic               inta_ni,
  output logic               int_req_o,
  output logic [TYPE_W-1:0]  data_o,
  output logic               data_oe_o
);
  logic              capture, drive;
  logic [TYPE_W-1:0] type_num;

  int_req_gate #(.NUM_REQ(NUM_REQ)) u_gate (
    .irq_ni   (irq_ni),
    .int_req_o(int_req_o)
  );

  ack_sequencer u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inta_ni  (inta_ni),
    .capture_o(capture),
    .drive_o  (drive)
  );

  type_latch #(.NUM_REQ(NUM_REQ)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .irq_ni   (irq_ni),
    .type_o   (type_num)
  );

  assign data_oe_o = drive;
  assign data_o    = drive ? type_num : '0;
endmodule

// File: rtl/irq_type_gen_chk.sv
module irq_type_gen_chk #(
  parameter int NUM_REQ = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_REQ-1:0] irq_ni,
  input logic               inta_ni,
  input logic               int_req_o,
  input logic [NUM_REQ:0]   data_o,
  input logic               data_oe_o
);
  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&irq_ni) |-> !int_req_o);
  assert_active_line_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(irq_ni) < NUM_REQ) |-> int_req_o);
  assert_top_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> data_o[NUM_REQ]);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));
  assert_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !inta_ni);
  assert_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));
endmodule

bind irq_type_gen irq_type_gen_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_ni   (irq_ni),
  .inta_ni  (inta_ni),
  .int_req_o(int_req_o),
  .data_o   (data_o),
  .data_oe_o(data_oe_o)
);

// File: tb/irq_type_gen_test.sv
module irq_type_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_n = 7'h7F;
  logic       inta_n = 1'b1;
  logic       int_req;
  logic [7:0] data;
  logic       data_oe;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  irq_type_gen uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .irq_ni   (irq_n),
    .inta_ni  (inta_n),
    .int_req_o(int_req),
    .data_o   (data),
    .data_oe_o(data_oe)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  // one full acknowledge sequence; pat are the active-low lines
  task automatic ack_seq(input logic [6:0] pat);
    logic [7:0] exp_byte;
    exp_byte = {1'b1, pat};
    step(); irq_n = pat; #1;
    check("R1", {8'h0, int_req}, {8'h0, (pat != 7'h7F)});
    inta_n = 1'b0;            // first pulse
    step(); #1;
    check("R7", {data_oe, data}, 9'h000);
    irq_n = ~pat;             // disturb lines after capture
    step(); inta_n = 1'b1;
    step(); inta_n = 1'b0;    // second pulse
    #1;
    check("R6", {8'h0, data_oe}, 9'h000);
    step(); #1;
    check("R3", {data_oe, data}, {1'b1, exp_byte});
    check("R5", {1'b0, data}, {1'b0, exp_byte});
    inta_n = 1'b1; #1;
    check("R6", {data_oe, data}, 9'h000);
    step(); irq_n = 7'h7F;
  endtask

  initial begin
    #1;
    check("R2", {data_oe, data}, 9'h000);
    repeat (3) step();
    rst_n = 1'b1;
    step(); #1;
    check("R2", {data_oe, data}, 9'h000);
    check("R1", {8'h0, int_req}, 9'h000);

    // R4 named examples
    ack_seq(7'b1111110);
    check("R4", {1'b0, data}, 9'h000);
    ack_seq(7'b1111100);

    // exhaustive sweep, back to back: exercises R8 recapture each time
    for (int p = 0; p < 128; p++) begin
      ack_seq(7'(p));
    end

    // R8: after return to idle a fresh first pulse must not drive
    step(); inta_n = 1'b0; step(); #1;
    check("R8", {data_oe, data}, 9'h000);
    inta_n = 1'b1; step();
    done = 1'b1;
  end

  // explicit R4 value checks on specific patterns
  initial begin
    logic got_fe, got_fc;
    got_fe = 1'b0; got_fc = 1'b0;
    while (!done) begin
      @(posedge clk); #1;
      if (data_oe && irq_n == 7'b0000001 && data == 8'hFE) got_fe = 1'b1;
      if (data_oe && irq_n == 7'b0000011 && data == 8'hFC) got_fc = 1'b1;
    end
    check("R4", {8'h0, got_fe}, 9'h001);
    check("R4", {8'h0, got_fc}, 9'h001);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule